// File: doc/BRIEF.md
# Reset-Time Debug Entry Controller

This block sits between a debug access path and a CPU core. It keeps a small control register written through a simple register port and a status register read through the same port. With those two registers a debugger can hold a core in debug mode from the moment system reset ends, so that the core never runs a single instruction. It can also halt a running core on request or on a software breakpoint, keep the core clock on while the core sleeps, and let the core resume with a go strobe.

The control register lives in the debug domain. Only the power-on reset, a low debug-session enable or the TAP's test-logic-reset indication clear it; system reset does not. A debugger therefore writes the request while system reset is held, releases reset, and finds the core halted. The status register shows two things, each one cycle late: whether the core is halted, and whether its clock is enabled.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After power-on reset the control register reads 0. It is also cleared on any clock edge where `tap_tlr_i` is high or `sess_en_i` is low, and writes at such an edge are lost.
- R2: Register address 0 (`acc_addr_i`=0) selects the control register. Bit 0 is the debug request, bit 1 is the clock wakeup and bit 2 is the software-breakpoint enable. All other bits read 0 and ignore writes. Address 1 selects the read-only status register, and writes to it change nothing.
- R3: System reset (`sys_rst_i`) does not clear the control register, and writes made while it is high take effect.
- R4: If the debug request is set when `sys_rst_i` falls, `halt_o` rises at the first clock edge after the release and `run_o` stays low throughout.
- R5: Setting the debug request while the core runs drops `run_o` right after the write edge, and `halt_o` rises one edge later.
- R6: A `go_i` strobe while halted with the debug request clear releases the core: `halt_o` falls and `run_o` rises after that edge. While the debug request is set, `go_i` has no effect.
- R7: Clearing the debug request leaves the core halted until a go strobe.
- R8: A `swbp_i` pulse while running halts the core at the next edge if the breakpoint enable is set. If the enable is clear, the pulse is ignored.
- R9: `clk_en_o` is high whenever the wakeup bit is set or `core_sleep_i` is low.
- R10: Status bit 0 shows `halt_o` delayed by one clock, status bit 1 shows `clk_en_o` delayed by one clock, and all other status bits read 0.
- R11: A low `sess_en_i` releases a halted core to run.
- R12: Asserting `sys_rst_i` ends any halt. A release with the debug request clear lets the core run from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for registers and core control |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| sys_rst_i | input | 1 | System reset held on the core, active high |
| sess_en_i | input | 1 | Debug session enable |
| tap_tlr_i | input | 1 | TAP is in test-logic-reset |
| acc_wr_i | input | 1 | Register write strobe |
| acc_addr_i | input | 1 | Register select: 0 control, 1 status |
| acc_wdata_i | input | DATA_W | Write data |
| acc_rdata_o | output | DATA_W | Read data of the selected register |
| go_i | input | 1 | Resume strobe from the debugger |
| swbp_i | input | 1 | Core decoded a software breakpoint instruction |
| core_sleep_i | input | 1 | Core asks for its clock to stop |
| clk_en_o | output | 1 | Core clock enable |
| halt_o | output | 1 | Core is halted in debug mode |
| run_o | output | 1 | Core may execute instructions |

## Verification
The bench releases system reset with the debug request set. A design that lets the core slip through would show `run_o` high for a cycle. It sends `go_i` while the request is still set, where a careless design resumes the core. It pulses `swbp_i` with the enable clear, where a careless design halts. It also drives session loss and test-logic-reset while the core is halted, and writes the status address. A design that ties register reset to system reset would read 0 after the reset window and fail to halt. The one-cycle status lag is checked in the cycle where `halt_o` is already high but status bit 0 must still read 0.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int unsigned CTRL_DREQ_BIT = 0;
  localparam int unsigned CTRL_WAKE_BIT = 1;
  localparam int unsigned CTRL_SWBE_BIT = 2;
  localparam int unsigned STAT_DBG_BIT  = 0;
  localparam int unsigned STAT_CLK_BIT  = 1;
  localparam logic        ADDR_CTRL     = 1'b0;
  localparam logic        ADDR_STAT     = 1'b1;

  typedef enum logic [1:0] {
    CORE_RST  = 2'd0,
    CORE_RUN  = 2'd1,
    CORE_HALT = 2'd2
  } core_st_e;
endpackage

// File: rtl/dbgc_rst_sync.sv
module dbgc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dbgc_ctrl_reg.sv
module dbgc_ctrl_reg
  import dbg_entry_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              sess_en_i,
  input  logic              tap_tlr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam logic [DATA_W-1:0] WMASK =
    DATA_W'((1 << CTRL_DREQ_BIT) | (1 << CTRL_WAKE_BIT) | (1 << CTRL_SWBE_BIT));

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_en;

  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = 1'b0;
    if (tap_tlr_i || !sess_en_i) begin
      ctrl_en = 1'b1;
      ctrl_d  = '0;
    end else if (wr_en_i) begin
      ctrl_en = 1'b1;
      ctrl_d  = wdata_i & WMASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/dbgc_core_seq.sv
module dbgc_core_seq
  import dbg_entry_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic sys_rst_i,
  input  logic sess_en_i,
  input  logic dreq_i,
  input  logic swbe_i,
  input  logic swbp_i,
  input  logic go_i,
  output logic halt_o,
  output logic run_o
);
  core_st_e state_q;
  core_st_e state_d;
  logic     state_en;

  always_comb begin
    state_d = state_q;
    if (sys_rst_i) begin
      state_d = CORE_RST;
    end else begin
      case (state_q)
        CORE_RST:  state_d = dreq_i ? CORE_HALT : CORE_RUN;
        CORE_RUN:  if (dreq_i || (swbp_i && swbe_i)) state_d = CORE_HALT;
        CORE_HALT: if (!sess_en_i || (go_i && !dreq_i)) state_d = CORE_RUN;
        default:   state_d = CORE_RST;
      endcase
    end
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        state_q <= CORE_RST;
    else if (state_en) state_q <= state_d;
  end

  assign halt_o = (state_q == CORE_HALT);
  assign run_o  = (state_q == CORE_RUN) && !dreq_i && !sys_rst_i;
endmodule

// File: rtl/dbgc_status.sv
module dbgc_status
  import dbg_entry_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              clk_en_i,
  output logic [DATA_W-1:0] status_o
);
  logic dbg_q, dbg_d;
  logic clk_q, clk_d;

  always_comb begin
    dbg_d = halt_i;
    clk_d = clk_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      dbg_q <= dbg_d;
      clk_q <= clk_d;
    end
  end

  always_comb begin
    status_o               = '0;
    status_o[STAT_DBG_BIT] = dbg_q;
    status_o[STAT_CLK_BIT] = clk_q;
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic              clk_i,
  input  logic              por_n_i,
  input  logic              sys_rst_i,
  input  logic              sess_en_i,
  input  logic              tap_tlr_i,
  input  logic              acc_wr_i,
  input  logic              acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic              go_i,
  input  logic              swbp_i,
  input  logic              core_sleep_i,
  output logic              clk_en_o,
  output logic              halt_o,
  output logic              run_o
);
  logic              rst_n_s;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] status;
  logic              wr_ctrl;

  dbgc_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk_i    (clk_i),
    .arst_n_i (por_n_i),
    .rst_n_o  (rst_n_s)
  );

  assign wr_ctrl = acc_wr_i && (acc_addr_i == ADDR_CTRL);

  dbgc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_n     (rst_n_s),
    .sess_en_i (sess_en_i),
    .tap_tlr_i (tap_tlr_i),
    .wr_en_i   (wr_ctrl),
    .wdata_i   (acc_wdata_i),
    .ctrl_o    (ctrl_q)
  );

  dbgc_core_seq u_seq (
    .clk_i     (clk_i),
    .rst_n     (rst_n_s),
    .sys_rst_i (sys_rst_i),
    .sess_en_i (sess_en_i),
    .dreq_i    (ctrl_q[CTRL_DREQ_BIT]),
    .swbe_i    (ctrl_q[CTRL_SWBE_BIT]),
    .swbp_i    (swbp_i),
    .go_i      (go_i),
    .halt_o    (halt_o),
    .run_o     (run_o)
  );

  assign clk_en_o = !core_sleep_i || ctrl_q[CTRL_WAKE_BIT];

  dbgc_status #(.DATA_W(DATA_W)) u_stat (
    .clk_i    (clk_i),
    .rst_n    (rst_n_s),
    .halt_i   (halt_o),
    .clk_en_i (clk_en_o),
    .status_o (status)
  );

  assign acc_rdata_o = (acc_addr_i == ADDR_STAT) ? status : ctrl_q;
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk
  import dbg_entry_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              sys_rst_i,
  input logic              sess_en_i,
  input logic              tap_tlr_i,
  input logic              acc_wr_i,
  input logic              acc_addr_i,
  input logic              go_i,
  input logic              swbp_i,
  input logic              run_o,
  input logic              halt_o,
  input logic [DATA_W-1:0] ctrl_q
);
  a_r1_clear_on_tlr_or_session: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tap_tlr_i || !sess_en_i) |=> (ctrl_q == '0));

  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl_q[DATA_W-1:3] == '0));

  a_r3_sysrst_keeps_ctrl: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sys_rst_i && sess_en_i && !tap_tlr_i && !(acc_wr_i && acc_addr_i == ADDR_CTRL))
      |=> $stable(ctrl_q));

  a_r4_halt_excludes_run: assert property (@(posedge clk_i) disable iff (!rst_n)
    halt_o |-> !run_o);

  a_r6_go_blocked_by_dreq: assert property (@(posedge clk_i) disable iff (!rst_n)
    (halt_o && go_i && ctrl_q[CTRL_DREQ_BIT] && !sys_rst_i && sess_en_i) |=> halt_o);

  a_r8_swbp_halts: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_o && swbp_i && ctrl_q[CTRL_SWBE_BIT]) |=> halt_o);

  a_r12_sysrst_ends_halt: assert property (@(posedge clk_i) disable iff (!rst_n)
    sys_rst_i |=> !halt_o);
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_s),
  .sys_rst_i  (sys_rst_i),
  .sess_en_i  (sess_en_i),
  .tap_tlr_i  (tap_tlr_i),
  .acc_wr_i   (acc_wr_i),
  .acc_addr_i (acc_addr_i),
  .go_i       (go_i),
  .swbp_i     (swbp_i),
  .run_o      (run_o),
  .halt_o     (halt_o),
  .ctrl_q     (ctrl_q)
);

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
  localparam int DW = 32;
  localparam int SEL_RD = 0, SEL_HALT = 1, SEL_RUN = 2, SEL_CKE = 3;

  logic          clk = 1'b0;
  logic          por_n, sys_rst, sess_en, tap_tlr, wr, addr, go, swbp, sleep;
  logic [DW-1:0] wdata, rdata;
  logic          clk_en, halt, run;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;
  item_t q[$];

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  dbg_entry_ctrl u_dbg_entry_ctrl (
    .clk_i(clk), .por_n_i(por_n), .sys_rst_i(sys_rst), .sess_en_i(sess_en),
    .tap_tlr_i(tap_tlr), .acc_wr_i(wr), .acc_addr_i(addr), .acc_wdata_i(wdata),
    .acc_rdata_o(rdata), .go_i(go), .swbp_i(swbp), .core_sleep_i(sleep),
    .clk_en_o(clk_en), .halt_o(halt), .run_o(run)
  );

  task automatic put(input string r, input int s, input logic [31:0] v);
    item_t it;
    it.req = r; it.sel = s; it.exp = v;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        case (it.sel)
          SEL_RD:   got = rdata;
          SEL_HALT: got = {31'b0, halt};
          SEL_RUN:  got = {31'b0, run};
          default:  got = {31'b0, clk_en};
        endcase
        vectors++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    por_n = 0; sys_rst = 1; sess_en = 1; tap_tlr = 0; wr = 0; addr = 0;
    wdata = '0; go = 0; swbp = 0; sleep = 0;
    repeat (3) step();
    por_n = 1;
    repeat (4) step();
    // R1 reset state
    put("R1", SEL_RD, 32'h0); put("R1", SEL_HALT, 0); put("R12", SEL_RUN, 0);
    step();
    // R2 R3: write all ones during system reset
    wr = 1; wdata = 32'hFFFF_FFFF;
    put("R2", SEL_RD, 32'h7); put("R3", SEL_RUN, 0);
    step();
    wdata = 32'h3;
    put("R3", SEL_RD, 32'h3);
    step();
    // R4 release with debug request
    wr = 0; sys_rst = 0; addr = 1;
    put("R4", SEL_HALT, 1); put("R4", SEL_RUN, 0); put("R10", SEL_RD, 32'h2);
    step();
    put("R4", SEL_HALT, 1); put("R4", SEL_RUN, 0); put("R10", SEL_RD, 32'h3);
    step();
    // R6 go ignored while request set
    go = 1;
    put("R6", SEL_HALT, 1); put("R6", SEL_RUN, 0);
    step();
    go = 0; addr = 0; wr = 1; wdata = 32'h6;
    put("R7", SEL_RD, 32'h6); put("R7", SEL_HALT, 1); put("R7", SEL_RUN, 0);
    step();
    wr = 0; sleep = 1;
    put("R9", SEL_CKE, 1); put("R7", SEL_HALT, 1);
    step();
    go = 1;
    put("R6", SEL_HALT, 0); put("R6", SEL_RUN, 1);
    step();
    go = 0; wr = 1; wdata = 32'h2;
    put("R9", SEL_CKE, 1);
    step();
    wdata = 32'h0;
    put("R9", SEL_CKE, 0);
    step();
    wr = 0; addr = 1;
    put("R10", SEL_RD, 32'h0);
    step();
    // R8 breakpoint with enable clear is ignored
    sleep = 0; addr = 0; swbp = 1;
    put("R8", SEL_HALT, 0); put("R8", SEL_RUN, 1); put("R9", SEL_CKE, 1);
    step();
    swbp = 0; wr = 1; wdata = 32'h4;
    put("R8", SEL_RUN, 1);
    step();
    wr = 0; swbp = 1; addr = 1;
    put("R8", SEL_HALT, 1); put("R8", SEL_RUN, 0); put("R10", SEL_RD, 32'h2);
    step();
    swbp = 0;
    put("R10", SEL_RD, 32'h3);
    step();
    go = 1; addr = 0;
    put("R6", SEL_HALT, 0); put("R6", SEL_RUN, 1);
    step();
    // R5 request while running
    go = 0; wr = 1; wdata = 32'h1;
    put("R5", SEL_RD, 32'h1); put("R5", SEL_RUN, 0); put("R5", SEL_HALT, 0);
    step();
    wr = 0;
    put("R5", SEL_HALT, 1);
    step();
    // R1 test-logic-reset clears, halt kept
    tap_tlr = 1;
    put("R1", SEL_RD, 32'h0); put("R7", SEL_HALT, 1);
    step();
    tap_tlr = 0; wr = 1; wdata = 32'h7;
    put("R1", SEL_RD, 32'h7); put("R6", SEL_HALT, 1);
    step();
    // R11 session loss
    wr = 0; sess_en = 0;
    put("R1", SEL_RD, 32'h0); put("R11", SEL_HALT, 0); put("R11", SEL_RUN, 1);
    step();
    wr = 1; wdata = 32'h7;
    put("R1", SEL_RD, 32'h0);
    step();
    // R3 R4 second reset window
    sess_en = 1; sys_rst = 1; wdata = 32'h3;
    put("R3", SEL_RD, 32'h3); put("R12", SEL_HALT, 0); put("R4", SEL_RUN, 0);
    step();
    addr = 1; wdata = 32'h0;
    put("R4", SEL_RUN, 0);
    step();
    wr = 0; addr = 0;
    put("R2", SEL_RD, 32'h3);
    step();
    sys_rst = 0;
    put("R4", SEL_HALT, 1); put("R4", SEL_RUN, 0);
    step();
    // R12 reset ends halt, release without request runs
    sys_rst = 1; wr = 1; wdata = 32'h0;
    put("R12", SEL_HALT, 0); put("R12", SEL_RUN, 0); put("R3", SEL_RD, 32'h0);
    step();
    wr = 0; sys_rst = 0;
    put("R12", SEL_HALT, 0); put("R12", SEL_RUN, 1);
    step();
    repeat (2) step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule